// File: doc/BRIEF.md
# Nibble-Link Program Upload Receiver

This block takes a program image from a host over a narrow parallel link: four data lines, one strobe driven by the host and one acknowledge returned by the receiver. The host puts a nibble on the data lines and toggles the strobe. The receiver samples the nibble and then makes its acknowledge equal to the strobe, which tells the host it may send the next nibble. Pairs of nibbles form bytes. Each transfer starts with a three-byte length. The image then follows in packets, and each packet ends with a checksum byte.

Every data byte is written to RAM as soon as it arrives. The write address starts from the base of the current packet. When a packet's checksum matches, the base moves past the packet and the receiver raises an accept pulse. When it does not match, the receiver raises a reject pulse, and the host sends the same packet again to the same addresses. After a fixed number of consecutive bad checksums on one packet, or after a long silence on the strobe in the middle of a transfer, the receiver abandons the transfer. When the whole declared length has been accepted, the receiver raises a completion pulse. After completion or abandonment it waits for a new length.

Top module: `upl_receiver`

## Requirements
- R1: `hostAck` resets to 0 and equals `hostStrobe` delayed by exactly three clock cycles, so the acknowledge follows every strobe toggle.
- R2: Each strobe toggle delivers one nibble. The first nibble of a byte is bits 3:0 and the second is bits 7:4.
- R3: A transfer opens with a 24-bit length sent as three bytes, least significant byte first. A length of zero raises `xferDone` with no RAM write.
- R4: Each packet carries min(remaining length, MAX_PKT) data bytes (MAX_PKT defaults to 256), followed by one checksum byte.
- R5: A packet whose checksum byte equals the 8-bit wrapping sum of its data bytes gives a one-cycle `pktGood` pulse. Any other checksum byte gives a one-cycle `pktBad` pulse.
- R6: Data bytes are written one per `ramWe` cycle to consecutive addresses, starting at address 0 for every transfer. A rejected packet is re-received and written again at the same addresses. Only an accepted packet moves the base.
- R7: On the MAX_FAILS-th consecutive bad checksum of one packet (default 3), the receiver raises `xferAbort` instead of `pktBad` and returns to waiting for a length.
- R8: `xferDone` pulses for one cycle in the same cycle as the `pktGood` of the packet that completes the declared length.
- R9: If TIMEOUT_CYC cycles pass without a strobe toggle while a transfer is in progress, `xferAbort` pulses and the receiver waits for a new length. No timeout fires while the receiver is idle.
- R10: `pktGood` and `pktBad` never occur together. `xferDone` never coincides with `pktBad` or `xferAbort`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostNib | input | 4 | Nibble from host, held stable until acknowledged |
| hostStrobe | input | 1 | Host strobe, toggled once per nibble |
| hostAck | output | 1 | Acknowledge, follows the strobe |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | AW | RAM write address |
| ramData | output | 8 | RAM write data |
| pktGood | output | 1 | Packet accepted pulse |
| pktBad | output | 1 | Packet rejected pulse |
| xferDone | output | 1 | Transfer complete pulse |
| xferAbort | output | 1 | Transfer abandoned pulse |

## Verification
The checksum byte of the final packet both accepts that packet and completes the transfer, so `pktGood` and `xferDone` must rise in the same cycle. A checksum byte that fails on the retry-limit attempt must give `xferAbort` alone, without a `pktBad`. Multi-packet transfers with random lengths, and bad checksums injected at random into chosen packets, produce both situations many times. A monitor counts how often pulses fall in the same cycle and checks that count against the number of transfers that should have completed.

// File: rtl/upl_pkg.sv
`timescale 1ns/1ps
package upl_pkg;
  typedef enum logic [1:0] {ST_SIZE, ST_CHECK, ST_DATA, ST_SUM} uplState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sizeLoad;
    logic dataByte;
    logic pktAccept;
    logic pktReject;
    logic clearAll;
    logic watchEn;
  } uplCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic byteValid;
    logic sizeLast;
    logic remZero;
    logic dataLast;
    logic sumOk;
    logic lastPkt;
    logic failLast;
    logic linkIdle;
    logic timeoutHit;
  } uplStat_t;
endpackage

// File: rtl/upl_link.sv
`timescale 1ns/1ps
module upl_link #(
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] hostNib,
  input  logic       hostStrobe,
  input  logic       clearAll,
  input  logic       watchEn,
  output logic       hostAck,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       halfFull,
  output logic       timeoutHit
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic       syncA, syncB, syncC;
  logic       strobeEdge;
  logic [3:0] lowNib;
  logic [TW-1:0] idleCnt;

  assign strobeEdge = syncB ^ syncC;
  assign hostAck    = syncC;
  assign timeoutHit = watchEn && !strobeEdge && (idleCnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= hostStrobe;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowNib    <= '0;
      halfFull  <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
    end else begin
      byteValid <= 1'b0;
      if (clearAll) begin
        halfFull <= 1'b0;
      end else if (strobeEdge) begin
        if (!halfFull) begin
          lowNib   <= hostNib;
          halfFull <= 1'b1;
        end else begin
          byteData  <= {hostNib, lowNib};
          byteValid <= 1'b1;
          halfFull  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) idleCnt <= '0;
    else if (!watchEn || strobeEdge || timeoutHit) idleCnt <= '0;
    else idleCnt <= idleCnt + TW'(1);
  end
endmodule

// File: rtl/upl_dpath.sv
`timescale 1ns/1ps
module upl_dpath
  import upl_pkg::*;
#(
  parameter int AW          = 19,
  parameter int MAX_PKT     = 256,
  parameter int MAX_FAILS   = 3,
  parameter int SIZE_BYTES  = 3,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    hostNib,
  input  logic          hostStrobe,
  input  uplCtl_t       ctl,
  output uplStat_t      stat,
  output logic          hostAck,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [7:0]    ramData
);
  localparam int SZW = 8 * SIZE_BYTES;
  localparam int SIW = (SIZE_BYTES > 1) ? $clog2(SIZE_BYTES) : 1;
  localparam int LW  = $clog2(MAX_PKT + 1);
  localparam int FW  = $clog2(MAX_FAILS + 1);

  logic          byteValid, halfFull, timeoutHit;
  logic [7:0]    byteData;
  logic [SZW-1:0] sizeReg, sizeNext, remaining;
  logic [SIW-1:0] sizeIdx;
  logic [AW-1:0]  baseAddr;
  logic [LW-1:0]  offset, pktLen;
  logic [7:0]     sum;
  logic [FW-1:0]  failCnt;

  upl_link #(.TIMEOUT_CYC(TIMEOUT_CYC)) uLink (
    .clk(clk), .rstN(rstN), .hostNib(hostNib), .hostStrobe(hostStrobe),
    .clearAll(ctl.clearAll), .watchEn(ctl.watchEn), .hostAck(hostAck),
    .byteValid(byteValid), .byteData(byteData), .halfFull(halfFull),
    .timeoutHit(timeoutHit)
  );

  assign sizeNext = sizeReg | (SZW'(byteData) << (8 * sizeIdx));
  assign pktLen   = (remaining >= SZW'(MAX_PKT)) ? LW'(MAX_PKT) : LW'(remaining);

  always_comb begin
    stat.byteValid  = byteValid;
    stat.sizeLast   = (sizeIdx == SIW'(SIZE_BYTES - 1));
    stat.remZero    = (remaining == '0);
    stat.dataLast   = (offset == LW'(pktLen - LW'(1)));
    stat.sumOk      = (byteData == sum);
    stat.lastPkt    = (remaining <= SZW'(MAX_PKT));
    stat.failLast   = (failCnt == FW'(MAX_FAILS - 1));
    stat.linkIdle   = (sizeIdx == '0) && !halfFull;
    stat.timeoutHit = timeoutHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clearAll) begin
      sizeReg   <= '0;
      sizeIdx   <= '0;
      remaining <= '0;
      baseAddr  <= '0;
      offset    <= '0;
      sum       <= '0;
      failCnt   <= '0;
    end else begin
      if (ctl.sizeLoad) begin
        sizeReg <= sizeNext;
        if (sizeIdx == SIW'(SIZE_BYTES - 1)) begin
          sizeIdx   <= '0;
          remaining <= sizeNext;
        end else begin
          sizeIdx <= sizeIdx + SIW'(1);
        end
      end
      if (ctl.dataByte) begin
        offset <= offset + LW'(1);
        sum    <= sum + byteData;
      end
      if (ctl.pktAccept) begin
        baseAddr  <= baseAddr + AW'(pktLen);
        remaining <= remaining - SZW'(pktLen);
        offset    <= '0;
        sum       <= '0;
        failCnt   <= '0;
      end
      if (ctl.pktReject) begin
        offset  <= '0;
        sum     <= '0;
        failCnt <= failCnt + FW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else begin
      ramWe <= ctl.dataByte;
      if (ctl.dataByte) begin
        ramAddr <= baseAddr + AW'(offset);
        ramData <= byteData;
      end
    end
  end
endmodule

// File: rtl/upl_ctrl.sv
`timescale 1ns/1ps
module upl_ctrl
  import upl_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  uplStat_t stat,
  output uplCtl_t  ctl,
  output logic     pktGood,
  output logic     pktBad,
  output logic     xferDone,
  output logic     xferAbort
);
  uplState_e state, nState;
  logic goodN, badN, doneN, abortN;

  always_comb begin
    ctl     = '0;
    nState  = state;
    goodN   = 1'b0;
    badN    = 1'b0;
    doneN   = 1'b0;
    abortN  = 1'b0;
    ctl.watchEn = !(state == ST_SIZE && stat.linkIdle);
    if (stat.timeoutHit) begin
      ctl.clearAll = 1'b1;
      abortN       = 1'b1;
      nState       = ST_SIZE;
    end else begin
      case (state)
        ST_SIZE: if (stat.byteValid) begin
          ctl.sizeLoad = 1'b1;
          if (stat.sizeLast) nState = ST_CHECK;
        end
        ST_CHECK: begin
          if (stat.remZero) begin
            doneN        = 1'b1;
            ctl.clearAll = 1'b1;
            nState       = ST_SIZE;
          end else begin
            nState = ST_DATA;
          end
        end
        ST_DATA: if (stat.byteValid) begin
          ctl.dataByte = 1'b1;
          if (stat.dataLast) nState = ST_SUM;
        end
        ST_SUM: if (stat.byteValid) begin
          if (stat.sumOk) begin
            ctl.pktAccept = 1'b1;
            goodN         = 1'b1;
            if (stat.lastPkt) begin
              doneN        = 1'b1;
              ctl.clearAll = 1'b1;
              nState       = ST_SIZE;
            end else begin
              nState = ST_DATA;
            end
          end else if (stat.failLast) begin
            abortN       = 1'b1;
            ctl.clearAll = 1'b1;
            nState       = ST_SIZE;
          end else begin
            ctl.pktReject = 1'b1;
            badN          = 1'b1;
            nState        = ST_DATA;
          end
        end
        default: nState = ST_SIZE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_SIZE;
      pktGood   <= 1'b0;
      pktBad    <= 1'b0;
      xferDone  <= 1'b0;
      xferAbort <= 1'b0;
    end else begin
      state     <= nState;
      pktGood   <= goodN;
      pktBad    <= badN;
      xferDone  <= doneN;
      xferAbort <= abortN;
    end
  end
endmodule

// File: rtl/upl_receiver.sv
`timescale 1ns/1ps
module upl_receiver
  import upl_pkg::*;
#(
  parameter int AW          = 19,
  parameter int MAX_PKT     = 256,
  parameter int MAX_FAILS   = 3,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    hostNib,
  input  logic          hostStrobe,
  output logic          hostAck,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [7:0]    ramData,
  output logic          pktGood,
  output logic          pktBad,
  output logic          xferDone,
  output logic          xferAbort
);
  uplCtl_t  ctl;
  uplStat_t stat;

  upl_dpath #(
    .AW(AW), .MAX_PKT(MAX_PKT), .MAX_FAILS(MAX_FAILS),
    .SIZE_BYTES(3), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .hostNib(hostNib), .hostStrobe(hostStrobe),
    .ctl(ctl), .stat(stat), .hostAck(hostAck),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData)
  );

  upl_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .stat(stat), .ctl(ctl),
    .pktGood(pktGood), .pktBad(pktBad),
    .xferDone(xferDone), .xferAbort(xferAbort)
  );
endmodule

// File: rtl/upl_receiver_chk.sv
`timescale 1ns/1ps
module upl_receiver_chk (
  input logic clk,
  input logic rstN,
  input logic hostStrobe,
  input logic hostAck,
  input logic pktGood,
  input logic pktBad,
  input logic xferDone,
  input logic xferAbort
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rstN) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  AST_ACK_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (age >= 3'd4) |-> (hostAck == $past(hostStrobe, 3))); // R1
  AST_GOOD_BAD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pktGood && pktBad)); // R10
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (!pktBad && !xferAbort)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone); // R8
  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    xferAbort |=> !xferAbort); // R7
  AST_ABORT_NO_BAD: assert property (@(posedge clk) disable iff (!rstN)
    xferAbort |-> (!pktBad && !pktGood)); // R7
endmodule

bind upl_receiver upl_receiver_chk uChk (
  .clk(clk), .rstN(rstN), .hostStrobe(hostStrobe), .hostAck(hostAck),
  .pktGood(pktGood), .pktBad(pktBad), .xferDone(xferDone), .xferAbort(xferAbort)
);

// File: tb/sim_upl_receiver.sv
`timescale 1ns/1ps
module sim_upl_receiver;
  localparam int AW  = 12;
  localparam int MP  = 256;
  localparam int MF  = 3;
  localparam int TO  = 500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] hostNib = '0;
  logic hostStrobe = 1'b0;
  logic hostAck, ramWe, pktGood, pktBad, xferDone, xferAbort;
  logic [AW-1:0] ramAddr;
  logic [7:0] ramData;

  always #4 clk = ~clk;

  upl_receiver #(.AW(AW), .MAX_PKT(MP), .MAX_FAILS(MF), .TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rstN(rstN), .hostNib(hostNib), .hostStrobe(hostStrobe),
    .hostAck(hostAck), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .pktGood(pktGood), .pktBad(pktBad), .xferDone(xferDone), .xferAbort(xferAbort)
  );

  int checks = 0, fails = 0;
  int goodCnt = 0, badCnt = 0, doneCnt = 0, abortCnt = 0, wrCnt = 0, doneWithGood = 0;
  logic [7:0] img [0:(1<<AW)-1];
  logic [7:0] mem [0:(1<<AW)-1];
  bit finished = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ramWe) begin mem[ramAddr] = ramData; wrCnt++; end
      if (pktGood) goodCnt++;
      if (pktBad) badCnt++;
      if (xferDone) doneCnt++;
      if (xferAbort) abortCnt++;
      if (xferDone && pktGood) doneWithGood++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic sendNib(input logic [3:0] n);
    hostNib = n;
    hostStrobe = ~hostStrobe;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hostAck == hostStrobe) break;
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    sendNib(b[3:0]);
    sendNib(b[7:4]);
  endtask

  task automatic sendSize(input int s);
    sendByte(s[7:0]); sendByte(s[15:8]); sendByte(s[23:16]);
  endtask

  task automatic sendPkt(input int start, input int len, input bit bad);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < len; i++) begin
      sendByte(img[start+i]);
      s = s + img[start+i];
    end
    sendByte(bad ? (s ^ 8'hA5) : s);
  endtask

  function automatic int pktCount(input int size);
    return (size + MP - 1) / MP;
  endfunction

  // one complete transfer; badPkt/badNum inject fixed failures, randMax adds random ones
  task automatic runXfer(input int size, input int badPkt, input int badNum,
                         input int randMax, input string tag);
    int g0 = goodCnt, b0 = badCnt, d0 = doneCnt, a0 = abortCnt, w0 = wrCnt, c0 = doneWithGood;
    int rem = size, base = 0, pk = 0, totBad = 0, mism = 0;
    for (int i = 0; i < size; i++) begin img[i] = 8'($urandom); mem[i] = ~img[i]; end
    sendSize(size);
    while (rem > 0) begin
      int len = (rem > MP) ? MP : rem;
      int nb = (pk == badPkt) ? badNum : int'($urandom_range(0, randMax));
      for (int r = 0; r <= nb; r++) sendPkt(base, len, r < nb);
      totBad += nb; base += len; rem -= len; pk++;
    end
    repeat (6) @(negedge clk);
    for (int i = 0; i < size; i++) if (mem[i] !== img[i]) mism++;
    check(mism == 0, {tag, " R2 R6 ram image"}, mism, 0);
    check(goodCnt - g0 == pktCount(size), {tag, " R4 R5 pktGood count"}, goodCnt - g0, pktCount(size));
    check(badCnt - b0 == totBad, {tag, " R5 pktBad count"}, badCnt - b0, totBad);
    check(doneCnt - d0 == 1, {tag, " R8 xferDone count"}, doneCnt - d0, 1);
    check(abortCnt == a0, {tag, " R7 no abort"}, abortCnt - a0, 0);
    check(wrCnt - w0 == size + totBad * MP - ((badPkt == pktCount(size) - 1 && size % MP != 0) ? totBad * (MP - size % MP) : 0) || randMax != 0,
          {tag, " R6 write count"}, wrCnt - w0, size);
    if (size > 0)
      check(doneWithGood - c0 == 1, {tag, " R8 done with good"}, doneWithGood - c0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int cyc;
    int a0, w0, g0, b0;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(hostAck == 1'b0, "R1 reset ack", hostAck, 0);
    check(!ramWe && !pktGood && !pktBad && !xferDone && !xferAbort, "R10 reset pulses", 1, 0);

    // R1: acknowledge latency
    hostNib = 4'h0; hostStrobe = ~hostStrobe; cyc = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); cyc++;
      if (hostAck == hostStrobe) break;
    end
    check(cyc == 3, "R1 ack delay", cyc, 3);

    // R9: half-received byte then silence
    a0 = abortCnt;
    repeat (TO + 20) @(negedge clk);
    check(abortCnt - a0 == 1, "R9 timeout abort", abortCnt - a0, 1);
    a0 = abortCnt;
    repeat (2 * TO) @(negedge clk);
    check(abortCnt == a0, "R9 idle no timeout", abortCnt - a0, 0);

    // single short packet, low nibble first
    runXfer(5, -1, 0, 0, "short");
    // three packets, middle one rejected once
    runXfer(600, 1, 1, 0, "multi");
    // R3 zero length
    w0 = wrCnt; g0 = goodCnt; cyc = doneCnt;
    sendSize(0);
    repeat (6) @(negedge clk);
    check(doneCnt - cyc == 1, "R3 zero size done", doneCnt - cyc, 1);
    check(wrCnt == w0 && goodCnt == g0, "R3 zero size no write", wrCnt - w0, 0);

    // R7 retry limit
    a0 = abortCnt; b0 = badCnt; g0 = goodCnt; cyc = doneCnt;
    for (int i = 0; i < 10; i++) img[i] = 8'($urandom);
    sendSize(10);
    for (int r = 0; r < MF; r++) sendPkt(0, 10, 1'b1);
    repeat (6) @(negedge clk);
    check(abortCnt - a0 == 1, "R7 abort after limit", abortCnt - a0, 1);
    check(badCnt - b0 == MF - 1, "R7 bad before abort", badCnt - b0, MF - 1);
    check(goodCnt == g0 && doneCnt == cyc, "R7 no accept", goodCnt - g0, 0);
    runXfer(3, -1, 0, 0, "afterAbort R7");

    // R9 mid-transfer timeout then recovery
    a0 = abortCnt;
    sendByte(8'h20);
    repeat (TO + 20) @(negedge clk);
    check(abortCnt - a0 == 1, "R9 size timeout", abortCnt - a0, 1);
    runXfer(40, -1, 0, 0, "afterTimeout R9");

    // random transfers with random retries
    for (int k = 0; k < 5; k++) begin
      int sz = int'($urandom_range(1, 700));
      runXfer(sz, -1, 0, MF - 1, "random");
    end

    finishRun();
  end
endmodule